// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Word-Select Generator

This block is the timing source for a serial audio master port. It divides the system clock into a serial bit clock and drives a word-select line that alternates between the left and right channel after a programmable number of bit-clock cycles. Within each word-select half it can optionally stop the bit clock once a programmed number of cycles has gone by. This lets a short sample be framed inside a longer slot.

The transmit and receive channels do not watch the bit clock themselves. Instead, the generator gives them single-cycle strobes on each bit-clock rising edge (sample point) and falling edge (shift point), plus a strobe that marks the first bit of every half-frame. It also gives them the frame-format selection, held constant for as long as the generator runs. The slot length, the gating length and the format are captured when the generator starts and do not change until it stops.

Top module: `i2s_bclk_gen`

## Requirements
- R1: While `clk_en` is 0 and the generator is idle, `sclk` and `ws` stay 0 and the `sample_stb` and `shift_stb` strobes stay 0.
- R2: `ws_size` selects the half-frame length N in bit-clock cycles: code 0 gives 16, code 1 gives 24 and code 2 gives 32. The bit clock has exactly N rising edges in each word-select half when gating is off.
- R3: The bit-clock period is 2×(`div_ratio`+1) system cycles, with equal high and low times. The first rising edge comes `div_ratio`+1 cycles after the start cycle.
- R4: `gate_code` 1, 2, 3 and 4 limit each half-frame to 12, 16, 20 and 24 bit-clock pulses. After that many pulses `sclk` stays low until the half ends. The word-select period of 2×N×(`div_ratio`+1) system cycles does not change.
- R5: `gate_code` 0 and the reserved codes 5 to 7 give no gating. A gating length that is equal to or larger than N also gives no gating. The reserved `ws_size` code 3 acts as 32 cycles.
- R6: In the start cycle `ws` is 0 (left channel) and `first_bit_stb` is 1. `ws` changes only at a bit-clock falling edge at the end of a half-frame, and `first_bit_stb` is 1 in exactly the cycles where `ws` changes or generation starts.
- R7: `sample_stb` is 1 exactly in the cycles where `sclk` has just risen, and `shift_stb` is 1 exactly in the cycles where `sclk` has just fallen.
- R8: Clearing `clk_en` while `sclk` is high lets the high phase run its full `div_ratio`+1 cycles before the generator goes idle. There is no shortened pulse.
- R9: `align_out` gives the `align_sel` value (1 standard, 2 right-aligned, 4 left-aligned) captured at start and holds it while running. While idle it follows `align_sel` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Starts (1) and stops (0) clock generation |
| div_ratio | input | DIV_W | Half-period of the bit clock minus one, in system cycles |
| ws_size | input | 2 | Half-frame length code |
| gate_code | input | 3 | Per-half-frame bit-clock gating code |
| align_sel | input | 3 | One-hot frame-format selection |
| sclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 left, 1 right |
| sample_stb | output | 1 | One-cycle strobe at each bit-clock rising edge |
| shift_stb | output | 1 | One-cycle strobe at each bit-clock falling edge |
| first_bit_stb | output | 1 | One-cycle strobe on the first bit of each half-frame |
| align_out | output | 3 | Frame format held for the channels |

## Verification
The bench counts rising edges between word-select changes for every size code, including the reserved one. A design that decodes the size wrongly, or that is off by one at the wrap, shows the wrong count. It also runs every gating code against slot lengths both larger and smaller than the gating length. A design that gates when the length does not fit would lose pulses, and one that lets gating move the word-select edges would change the measured frame period. It clears the enable in the middle of a high phase and measures the pulse width, which catches a generator that cuts the clock short. Finally, it changes the format input during a run to catch a format that leaks through instead of being held.

// File: rtl/i2s_bclk_pkg.sv
package i2s_bclk_pkg;

    localparam int BCNT_W = 6;
    typedef logic [BCNT_W-1:0] bcnt_t;

    // Half-frame length in bit-clock cycles; reserved code maps to 32
    function automatic bcnt_t half_len(input logic [1:0] code);
        case (code)
            2'd0:    half_len = bcnt_t'(16);
            2'd1:    half_len = bcnt_t'(24);
            default: half_len = bcnt_t'(32);
        endcase
    endfunction

    // Gating length; 0 means free running (also when it would not fit)
    function automatic bcnt_t gate_len(input logic [2:0] code, input bcnt_t n);
        bcnt_t g;
        case (code)
            3'd1:    g = bcnt_t'(12);
            3'd2:    g = bcnt_t'(16);
            3'd3:    g = bcnt_t'(20);
            3'd4:    g = bcnt_t'(24);
            default: g = '0;
        endcase
        gate_len = (g >= n) ? '0 : g;
    endfunction

    typedef struct packed {
        logic       run;
        logic       phase;
        bcnt_t      bitcnt;
        logic       ws;
        logic       sclk;
        logic       sample;
        logic       shift;
        logic       first;
        bcnt_t      nlen;
        bcnt_t      glen;
        logic [2:0] align;
    } frame_st_t;

endpackage

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q >= div_i);
        cnt_d  = cnt_q;
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_CNT_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0)) else $error("divider not cleared"); // R3

endmodule

// File: rtl/i2s_bclk_frame.sv
module i2s_bclk_frame
    import i2s_bclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       tick_i,
    input  logic [1:0] ws_size_i,
    input  logic [2:0] gate_i,
    input  logic [2:0] align_i,
    output logic       run_o,
    output logic       sclk_o,
    output logic       ws_o,
    output logic       sample_o,
    output logic       shift_o,
    output logic       first_o,
    output logic [2:0] align_o
);

    frame_st_t st_d, st_q;
    bcnt_t     cfg_n;

    always_comb begin
        st_d        = st_q;
        st_d.sample = 1'b0;
        st_d.shift  = 1'b0;
        st_d.first  = 1'b0;
        cfg_n       = half_len(ws_size_i);
        if (!st_q.run) begin
            // Idle: track configuration, hold lines low
            st_d.align  = align_i;
            st_d.nlen   = cfg_n;
            st_d.glen   = gate_len(gate_i, cfg_n);
            st_d.phase  = 1'b0;
            st_d.bitcnt = '0;
            st_d.ws     = 1'b0;
            if (en_i) begin
                st_d.run   = 1'b1;
                st_d.first = 1'b1;
            end
        end else if (!en_i && !st_q.phase) begin
            // Stop during low phase: no pulse is cut
            st_d.run    = 1'b0;
            st_d.bitcnt = '0;
            st_d.ws     = 1'b0;
        end else if (tick_i) begin
            if (!st_q.phase) begin
                st_d.phase = 1'b1;
            end else begin
                st_d.phase = 1'b0;
                if (!en_i) begin
                    st_d.run    = 1'b0;
                    st_d.bitcnt = '0;
                    st_d.ws     = 1'b0;
                end else if (st_q.bitcnt == st_q.nlen - 1'b1) begin
                    st_d.bitcnt = '0;
                    st_d.ws     = ~st_q.ws;
                    st_d.first  = 1'b1;
                end else begin
                    st_d.bitcnt = st_q.bitcnt + 1'b1;
                end
            end
        end
        st_d.sclk   = st_d.run && st_d.phase &&
                      !((st_d.glen != '0) && (st_d.bitcnt >= st_d.glen));
        st_d.sample = st_d.sclk && !st_q.sclk;
        st_d.shift  = !st_d.sclk && st_q.sclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o    = st_q.run;
    assign sclk_o   = st_q.sclk;
    assign ws_o     = st_q.ws;
    assign sample_o = st_q.sample;
    assign shift_o  = st_q.shift;
    assign first_o  = st_q.first;
    assign align_o  = st_q.align;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (!st_q.sclk && !st_q.ws)) else $error("idle lines active"); // R1
    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.bitcnt < st_q.nlen)) else $error("bit count past slot"); // R2
    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sclk) |-> $past(tick_i)) else $error("rise off divider tick"); // R3
    AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.sclk) |-> $past(tick_i)) else $error("runt pulse"); // R8
    AST_WS_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.ws) || ($fell(st_q.ws) && st_q.run)) |-> st_q.first) else $error("ws change unmarked"); // R6
    AST_ALIGN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run)) |-> $stable(st_q.align)) else $error("format moved while running"); // R9

endmodule

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic [1:0]       ws_size,
    input  logic [2:0]       gate_code,
    input  logic [2:0]       align_sel,
    output logic             sclk,
    output logic             ws,
    output logic             sample_stb,
    output logic             shift_stb,
    output logic             first_bit_stb,
    output logic [2:0]       align_out
);

    logic run_w;
    logic tick_w;

    i2s_bclk_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_w),
        .div_i  (div_ratio),
        .tick_o (tick_w)
    );

    i2s_bclk_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (clk_en),
        .tick_i    (tick_w),
        .ws_size_i (ws_size),
        .gate_i    (gate_code),
        .align_i   (align_sel),
        .run_o     (run_w),
        .sclk_o    (sclk),
        .ws_o      (ws),
        .sample_o  (sample_stb),
        .shift_o   (shift_stb),
        .first_o   (first_bit_stb),
        .align_o   (align_out)
    );

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && shift_stb)) else $error("both strobes set"); // R7

endmodule

// File: tb/i2s_bclk_gen_tb.sv
module i2s_bclk_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic [7:0] div_ratio = 8'd1;
    logic [1:0] ws_size = 2'd0;
    logic [2:0] gate_code = 3'd0;
    logic [2:0] align_sel = 3'd0;
    logic       sclk, ws, sample_stb, shift_stb, first_bit_stb;
    logic [2:0] align_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    i2s_bclk_gen #(.DIV_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .div_ratio(div_ratio),
        .ws_size(ws_size), .gate_code(gate_code), .align_sel(align_sel),
        .sclk(sclk), .ws(ws), .sample_stb(sample_stb), .shift_stb(shift_stb),
        .first_bit_stb(first_bit_stb), .align_out(align_out)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Start generation; leaves the bench in the start cycle
    task automatic start_gen(input int d, input int wsz, input int g, input int al);
        div_ratio = 8'(d);
        ws_size   = 2'(wsz);
        gate_code = 3'(g);
        align_sel = 3'(al);
        step();
        clk_en = 1'b1;
        step();
        chk(first_bit_stb == 1'b1, "R6 start strobe", int'(first_bit_stb), 1);
        chk(ws == 1'b0, "R6 start ws left", int'(ws), 0);
    endtask

    task automatic stop_gen(input int d);
        clk_en = 1'b0;
        for (int i = 0; i < 2 * (d + 1) + 2; i++) step();
    endtask

    // Steps until ws changes; counts rises, cycles and strobe mismatches
    task automatic count_half(output int rises, output int cycles, output int bad_stb);
        logic prev_s, prev_w;
        rises = 0; cycles = 0; bad_stb = 0;
        prev_s = sclk; prev_w = ws;
        for (int i = 0; i < 5000; i++) begin
            step();
            cycles++;
            if (sample_stb) rises++;
            if (sample_stb != (sclk && !prev_s)) bad_stb++;
            if (shift_stb != (!sclk && prev_s)) bad_stb++;
            prev_s = sclk;
            if (ws != prev_w) break;
        end
    endtask

    task automatic t_reset();
        chk(sclk == 0 && ws == 0, "R1 reset lines", int'({sclk, ws}), 0);
        chk(sample_stb == 0 && shift_stb == 0 && first_bit_stb == 0, "R1 reset strobes",
            int'({sample_stb, shift_stb, first_bit_stb}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            chk(sclk == 0 && ws == 0 && sample_stb == 0 && shift_stb == 0,
                "R1 idle quiet", int'({sclk, ws, sample_stb, shift_stb}), 0);
        end
    endtask

    task automatic t_ws_sizes();
        int r, c, b, expn;
        for (int code = 0; code < 4; code++) begin
            expn = (code == 0) ? 16 : (code == 1) ? 24 : 32;
            start_gen(1, code, 0, 1);
            count_half(r, c, b);
            chk(r == expn, (code == 3) ? "R5 reserved size" : "R2 rises per half", r, expn);
            chk(ws == 1'b1 && first_bit_stb == 1'b1, "R6 ws toggle strobe",
                int'({ws, first_bit_stb}), 3);
            chk(b == 0, "R7 strobe edges", b, 0);
            count_half(r, c, b);
            chk(r == expn, "R2 second half rises", r, expn);
            chk(c == 2 * expn * 2, "R2 half period cycles", c, 4 * expn);
            stop_gen(1);
        end
    endtask

    task automatic t_gating();
        int wsz[7] = '{0, 1, 2, 0, 1, 2, 0};
        int gc[7]  = '{1, 3, 4, 2, 4, 6, 7};
        int ex[7]  = '{12, 20, 24, 16, 24, 32, 16};
        int r, c, b, n;
        for (int k = 0; k < 7; k++) begin
            n = (wsz[k] == 0) ? 16 : (wsz[k] == 1) ? 24 : 32;
            start_gen(1, wsz[k], gc[k], 1);
            count_half(r, c, b);
            count_half(r, c, b);
            chk(r == ex[k], (ex[k] == n) ? "R5 no gating" : "R4 gated rises", r, ex[k]);
            chk(c == 4 * n, "R4 ws period kept", c, 4 * n);
            chk(b == 0, "R7 strobes with gating", b, 0);
            stop_gen(1);
        end
    endtask

    task automatic t_period();
        int w;
        start_gen(2, 0, 0, 1);
        w = 0;
        while (!sample_stb && w < 100) begin step(); w++; end
        chk(w == 3, "R3 first rise delay", w, 3);
        w = 0;
        while (sclk && w < 100) begin step(); w++; end
        chk(w == 3, "R3 high time", w, 3);
        w = 0;
        while (!sample_stb && w < 100) begin step(); w++; end
        chk(w == 3, "R3 low time", w, 3);
        stop_gen(2);
    endtask

    task automatic t_disable_high();
        int w;
        start_gen(3, 0, 0, 1);
        while (!sample_stb) step();
        clk_en = 1'b0;
        w = 0;
        while (sclk && w < 100) begin step(); w++; end
        chk(w == 4, "R8 full high phase", w, 4);
        for (int i = 0; i < 30; i++) begin
            step();
            chk(sclk == 0 && ws == 0 && sample_stb == 0, "R1 stays idle",
                int'({sclk, ws, sample_stb}), 0);
        end
    endtask

    task automatic t_align();
        start_gen(1, 0, 0, 2);
        chk(align_out == 3'd2, "R9 format captured", int'(align_out), 2);
        align_sel = 3'd4;
        for (int i = 0; i < 10; i++) step();
        chk(align_out == 3'd2, "R9 format held", int'(align_out), 2);
        stop_gen(1);
        step();
        chk(align_out == 3'd4, "R9 follows when idle", int'(align_out), 4);
        align_sel = 3'd1;
        step();
        chk(align_out == 3'd1, "R9 idle one cycle", int'(align_out), 1);
    endtask

    initial begin
        step();
        t_reset();
        t_period();
        t_ws_sizes();
        t_gating();
        t_disable_high();
        t_align();
        report();
    end

endmodule